// File: doc/BRIEF.md
# T1 Remote and AIS Alarm Detector

This block watches a framed T1 receive stream and raises the alarm indications a terminal needs from the far end. It flags a remote (yellow) alarm in three ways. In D4 mode it watches the second bit of every channel. In D4 mode it also watches the S-bit of the last frame of the superframe. In extended-superframe mode it watches for a fixed codeword on the data link. Separately, it raises an AIS (blue) indication when the line carries almost no zeros. Frame alignment is done upstream. Each received bit arrives with a strobe, its position in the 193-bit frame (0 = framing bit, 192 = last payload bit) and the frame number within the multiframe.

For the channel-bit alarm, time is counted in frames of 125 µs. One integration period is `PERIOD_FRAMES` frames (384 frames = 48 ms by default). The end of each period gives a sample flag. A level output integrates those samples. It sets after `SET_FRAMES` frames of consecutive passing periods (600 ms) and clears after `CLR_FRAMES` frames of consecutive failing periods (200 ms). Both times are rounded up to whole periods. The AIS check counts bits in fixed windows of `WIN_BITS` bit times (4632 bits = 3 ms by default) and decides once at the end of each window.

Top module: `t1_alarm_det`

## Requirements
- R1: After synchronous reset, every alarm output is 0.
- R2: A channel signal bit is a strobed bit at a position p with p ≥ 1 and (p−1) mod 8 = 1. An integration period passes when at most `ONES_TOL` (16) of its channel signal bits are 1. Ones at any other position have no effect.
- R3: A period ends on the strobe at position 192 of its `PERIOD_FRAMES`-th frame. The frames are counted from reset or from entry into D4 mode. `d4_yel48` then takes the pass result of that period and holds it until the next period ends.
- R4: `d4_yel` sets at the end of the ceil(`SET_FRAMES`/`PERIOD_FRAMES`)-th consecutive passing period.
- R5: `d4_yel` clears at the end of the ceil(`CLR_FRAMES`/`PERIOD_FRAMES`)-th consecutive failing period. A passing period restarts the failing count.
- R6: In D4 mode, the bit at position 0 with `frm_num` = 11 is the S-bit of the final frame. `d4_yel_sec` is updated on each such bit and is 1 exactly when this bit and the previous one were both 1. The bit at position 0 in any other frame is ignored.
- R7: In ESF mode, data-link bits are the position-0 bits of frames with even `frm_num`. They are grouped into 16-bit codewords starting at the first data-link bit after reset, first bit received as the MSB. A codeword matches when it equals 16'h00FF, i.e. eight zeros followed by eight ones.
- R8: `esf_yel` is updated after each codeword and is 1 when at least `VOTE_MIN` (7) of the last `VOTE_LEN` (10) codewords matched.
- R9: At the end of each window of `WIN_BITS` strobed bits, counted from reset, `blue` becomes 1 when fewer than `ZERO_MIN` (6) zeros were received in that window, and 0 otherwise. Mid-window it holds.
- R10: While `esf_mode` = 1, `d4_yel`, `d4_yel48` and `d4_yel_sec` are held at 0. While `esf_mode` = 0, `esf_yel` is held at 0.
- R11: Outputs change only on clock edges where `bit_vld` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_vld | input | 1 | Strobe: a received bit is present this cycle |
| bit_dat | input | 1 | Received bit value |
| bit_pos | input | 8 | Position of the bit in its frame, 0..192 |
| frm_num | input | 5 | Frame number in the multiframe (0..11 D4, 0..23 ESF) |
| esf_mode | input | 1 | 1 = extended superframe, 0 = D4 |
| d4_yel | output | 1 | Integrated D4 remote alarm level |
| d4_yel48 | output | 1 | Pass result of the last integration period |
| d4_yel_sec | output | 1 | S-bit remote alarm flag |
| esf_yel | output | 1 | Data-link codeword remote alarm flag |
| blue | output | 1 | AIS indication |

## Verification
The bench puts exactly 16 and then 17 ones into an integration period, to find an off-by-one in the tolerance compare. It fills every non-signal bit with ones, so a design that decodes the wrong channel position fails every period. It steps the vote through 6, 7 and back to 6 matches of 10, so a design that keeps too short or too long a history, or compares with the wrong bound, flips the flag a codeword early or late. It checks that the AIS indication holds mid-window after the zero count has crossed the limit, and that S-bits in the wrong frame and traffic in the other framing mode leave the flags alone. A design that decides early or filters the wrong frames would show a change there.

// File: rtl/t1a_pkg.sv
// Shared constants and helpers for the T1 alarm detector.
// Assumes a 193-bit frame, position 0 being the framing bit.
package t1a_pkg;
    localparam int          POS_W       = 8;
    localparam int          FRM_W       = 5;
    localparam logic [7:0]  FRAME_LAST  = 8'd192;
    localparam logic [4:0]  SBIT_FRAME  = 5'd11;
    localparam int          CW_LEN      = 16;
    localparam logic [15:0] CW_YELLOW   = 16'h00FF;

    // True when a position carries the second bit of a channel.
    function automatic logic is_sig_bit(input logic [7:0] pos);
        logic [7:0] q;
        q = pos - 8'd1;
        return (pos != 8'd0) && (q[2:0] == 3'd1);
    endfunction
endpackage

// File: rtl/t1a_d4_integ.sv
// D4 channel-bit remote alarm integrator.
// Counts ones in the second bit of every channel over a period of frames,
// gives a per-period pass flag and an integrated level with set/clear runs.
// Assumes full frames are strobed and position 192 closes each frame.
module t1a_d4_integ
    import t1a_pkg::*;
#(
    parameter int PERIOD_FRAMES = 384,
    parameter int SET_PER       = 13,
    parameter int CLR_PER       = 5,
    parameter int ONES_TOL      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             bit_vld,
    input  logic             bit_dat,
    input  logic [POS_W-1:0] bit_pos,
    output logic             yel_lvl,
    output logic             yel_smp
);
    localparam int FW = $clog2(PERIOD_FRAMES + 1);
    localparam int OW = $clog2(ONES_TOL + 2);
    localparam int SW = $clog2(SET_PER + 1);
    localparam int CW = $clog2(CLR_PER + 1);

    logic [FW-1:0] frm_cnt;
    logic [OW-1:0] ones_cnt;
    logic [SW-1:0] pass_run;
    logic [CW-1:0] fail_run;
    logic          frame_end, period_end, pass;

    // Decode frame and period boundaries and the period verdict.
    always_comb begin
        frame_end  = bit_vld && (bit_pos == FRAME_LAST);
        period_end = frame_end && (frm_cnt == FW'(PERIOD_FRAMES - 1));
        pass       = (ones_cnt <= OW'(ONES_TOL));
    end

    // Count ones, close periods and run the set/clear integration.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            frm_cnt  <= '0;
            ones_cnt <= '0;
            pass_run <= '0;
            fail_run <= '0;
            yel_lvl  <= 1'b0;
            yel_smp  <= 1'b0;
        end else begin
            if (bit_vld && bit_dat && is_sig_bit(bit_pos) &&
                ones_cnt != OW'(ONES_TOL + 1))
                ones_cnt <= ones_cnt + 1'b1;
            if (frame_end)
                frm_cnt <= period_end ? '0 : frm_cnt + 1'b1;
            if (period_end) begin
                ones_cnt <= '0;
                yel_smp  <= pass;
                if (pass) begin
                    fail_run <= '0;
                    if (pass_run != SW'(SET_PER)) pass_run <= pass_run + 1'b1;
                    if (pass_run >= SW'(SET_PER - 1)) yel_lvl <= 1'b1;
                end else begin
                    pass_run <= '0;
                    if (fail_run != CW'(CLR_PER)) fail_run <= fail_run + 1'b1;
                    if (fail_run >= CW'(CLR_PER - 1)) yel_lvl <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/t1a_esf_vote.sv
// ESF data-link codeword detector with a sliding majority vote.
// Assembles 16-bit codewords from data-link bits (first bit = MSB) and
// flags when enough of the recent codewords equal the remote alarm code.
module t1a_esf_vote
    import t1a_pkg::*;
#(
    parameter int VOTE_LEN = 10,
    parameter int VOTE_MIN = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic dl_vld,
    input  logic dl_bit,
    output logic yel
);
    localparam int BW = $clog2(CW_LEN);

    logic [CW_LEN-1:0]   sh, sh_next;
    logic [BW-1:0]       bcnt;
    logic [VOTE_LEN-1:0] hist, hist_next;

    // Next shift contents and next match history.
    always_comb begin
        sh_next   = {sh[CW_LEN-2:0], dl_bit};
        hist_next = {hist[VOTE_LEN-2:0], (sh_next == CW_YELLOW)};
    end

    // Shift bits, close codewords and update the vote.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sh   <= '0;
            bcnt <= '0;
            hist <= '0;
            yel  <= 1'b0;
        end else if (dl_vld) begin
            sh   <= sh_next;
            bcnt <= bcnt + 1'b1;
            if (bcnt == BW'(CW_LEN - 1)) begin
                hist <= hist_next;
                yel  <= ($countones(hist_next) >= VOTE_MIN);
            end
        end
    end
endmodule

// File: rtl/t1a_ais_win.sv
// AIS detector: counts zeros in fixed windows of strobed bits and decides
// at each window end. Windows are counted from reset.
module t1a_ais_win #(
    parameter int WIN_BITS = 4632,
    parameter int ZERO_MIN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_dat,
    output logic blue
);
    localparam int WW = $clog2(WIN_BITS);
    localparam int ZW = $clog2(ZERO_MIN + 1);

    logic [WW-1:0] win_cnt;
    logic [ZW-1:0] zc, zc_next;

    // Saturating zero count including the current bit.
    always_comb begin
        zc_next = zc;
        if (!bit_dat && zc != ZW'(ZERO_MIN)) zc_next = zc + 1'b1;
    end

    // Advance the window and decide at its last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
            zc      <= '0;
            blue    <= 1'b0;
        end else if (bit_vld) begin
            if (win_cnt == WW'(WIN_BITS - 1)) begin
                blue    <= (zc_next < ZW'(ZERO_MIN));
                win_cnt <= '0;
                zc      <= '0;
            end else begin
                win_cnt <= win_cnt + 1'b1;
                zc      <= zc_next;
            end
        end
    end
endmodule

// File: rtl/t1_alarm_det.sv
// T1 remote (yellow) and AIS (blue) alarm detector, top level.
// Assumes an aligned bit position and frame number are supplied upstream.
module t1_alarm_det
    import t1a_pkg::*;
#(
    parameter int PERIOD_FRAMES = 384,
    parameter int SET_FRAMES    = 4800,
    parameter int CLR_FRAMES    = 1600,
    parameter int ONES_TOL      = 16,
    parameter int VOTE_LEN      = 10,
    parameter int VOTE_MIN      = 7,
    parameter int WIN_BITS      = 4632,
    parameter int ZERO_MIN      = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_vld,
    input  logic       bit_dat,
    input  logic [7:0] bit_pos,
    input  logic [4:0] frm_num,
    input  logic       esf_mode,
    output logic       d4_yel,
    output logic       d4_yel48,
    output logic       d4_yel_sec,
    output logic       esf_yel,
    output logic       blue
);
    localparam int SET_PER = (SET_FRAMES + PERIOD_FRAMES - 1) / PERIOD_FRAMES;
    localparam int CLR_PER = (CLR_FRAMES + PERIOD_FRAMES - 1) / PERIOD_FRAMES;

    logic sbit_hit, sbit_prev, dl_vld;

    // Select the S-bit of the final D4 frame and the ESF data-link bits.
    always_comb begin
        sbit_hit = bit_vld && !esf_mode && (bit_pos == 8'd0) && (frm_num == SBIT_FRAME);
        dl_vld   = bit_vld && esf_mode && (bit_pos == 8'd0) && !frm_num[0];
    end

    // Secondary D4 alarm: two consecutive final-frame S-bits at one.
    always_ff @(posedge clk) begin
        if (!rst_n || esf_mode) begin
            sbit_prev  <= 1'b0;
            d4_yel_sec <= 1'b0;
        end else if (sbit_hit) begin
            sbit_prev  <= bit_dat;
            d4_yel_sec <= sbit_prev && bit_dat;
        end
    end

    t1a_d4_integ #(
        .PERIOD_FRAMES(PERIOD_FRAMES), .SET_PER(SET_PER),
        .CLR_PER(CLR_PER), .ONES_TOL(ONES_TOL)
    ) u_d4 (
        .clk(clk), .rst_n(rst_n), .en(!esf_mode), .bit_vld(bit_vld),
        .bit_dat(bit_dat), .bit_pos(bit_pos),
        .yel_lvl(d4_yel), .yel_smp(d4_yel48)
    );

    t1a_esf_vote #(.VOTE_LEN(VOTE_LEN), .VOTE_MIN(VOTE_MIN)) u_esf (
        .clk(clk), .rst_n(rst_n), .en(esf_mode), .dl_vld(dl_vld),
        .dl_bit(bit_dat), .yel(esf_yel)
    );

    t1a_ais_win #(.WIN_BITS(WIN_BITS), .ZERO_MIN(ZERO_MIN)) u_ais (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_dat(bit_dat),
        .blue(blue)
    );
endmodule

// File: rtl/t1a_checker.sv
// Property checker for t1_alarm_det, attached by bind.
module t1a_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_vld,
    input logic       bit_dat,
    input logic [7:0] bit_pos,
    input logic [4:0] frm_num,
    input logic       esf_mode,
    input logic       d4_yel,
    input logic       d4_yel48,
    input logic       d4_yel_sec,
    input logic       esf_yel,
    input logic       blue
);
    AST_SET_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d4_yel) |-> d4_yel48); // R4
    AST_CLR_NEEDS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(d4_yel) |-> !d4_yel48); // R5
    AST_SEC_NEEDS_SBIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d4_yel_sec) |-> $past(bit_vld && bit_dat && bit_pos == 8'd0 && frm_num == 5'd11)); // R6
    AST_ESF_GATES_D4: assert property (@(posedge clk) disable iff (!rst_n)
        (esf_mode && $past(esf_mode)) |-> (!d4_yel && !d4_yel48 && !d4_yel_sec)); // R10
    AST_D4_GATES_ESF: assert property (@(posedge clk) disable iff (!rst_n)
        (!esf_mode && !$past(esf_mode)) |-> !esf_yel); // R10
    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> ($stable(d4_yel) && $stable(d4_yel48) && $stable(d4_yel_sec)
                      && $stable(esf_yel) && $stable(blue))); // R11
endmodule

bind t1_alarm_det t1a_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_dat(bit_dat),
    .bit_pos(bit_pos), .frm_num(frm_num), .esf_mode(esf_mode),
    .d4_yel(d4_yel), .d4_yel48(d4_yel48), .d4_yel_sec(d4_yel_sec),
    .esf_yel(esf_yel), .blue(blue)
);

// File: tb/tb_t1_alarm_det.sv
// Directed bench for t1_alarm_det with shortened timing parameters.
module tb_t1_alarm_det;
    localparam int CLK_PERIOD = 10;
    localparam int PF   = 4;    // frames per period
    localparam int WIN  = 200;  // AIS window bits

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0, bit_dat = 1'b0, esf_mode = 1'b0;
    logic [7:0] bit_pos = 8'd0;
    logic [4:0] frm_num = 5'd0;
    logic       d4_yel, d4_yel48, d4_yel_sec, esf_yel, blue;

    int n_chk = 0, n_fail = 0;
    int dl_idx = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    t1_alarm_det #(
        .PERIOD_FRAMES(PF), .SET_FRAMES(12), .CLR_FRAMES(8), .ONES_TOL(16),
        .VOTE_LEN(10), .VOTE_MIN(7), .WIN_BITS(WIN), .ZERO_MIN(6)
    ) dut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_dat(bit_dat),
        .bit_pos(bit_pos), .frm_num(frm_num), .esf_mode(esf_mode),
        .d4_yel(d4_yel), .d4_yel48(d4_yel48), .d4_yel_sec(d4_yel_sec),
        .esf_yel(esf_yel), .blue(blue)
    );

    task automatic check(input logic got, input logic exp, input string req, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        bit_vld = 1'b0; esf_mode = mode; rst_n = 1'b0; dl_idx = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drive(input logic d, input logic [7:0] p, input logic [4:0] f);
        @(negedge clk);
        bit_vld = 1'b1; bit_dat = d; bit_pos = p; frm_num = f;
    endtask

    task automatic idle();
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    // One frame: n_ones channels carry a 1 in their second bit, all else 1.
    task automatic send_frame(input int n_ones);
        for (int p = 0; p < 193; p++) begin
            logic d;
            if (p != 0 && ((p - 1) % 8) == 1) d = (((p - 1) / 8) < n_ones);
            else d = 1'b1;
            drive(d, 8'(p), 5'd3);
        end
    endtask

    task automatic send_period(input int o0, input int o1, input int o2, input int o3);
        send_frame(o0); send_frame(o1); send_frame(o2); send_frame(o3);
        idle();
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        @(negedge clk);
        check(d4_yel, 1'b0, "R1", "d4_yel"); check(d4_yel48, 1'b0, "R1", "d4_yel48");
        check(d4_yel_sec, 1'b0, "R1", "d4_yel_sec"); check(esf_yel, 1'b0, "R1", "esf_yel");
        check(blue, 1'b0, "R1", "blue");
    endtask

    task automatic t_d4();
        do_reset(1'b0);
        send_period(0, 0, 0, 0);
        check(d4_yel48, 1'b1, "R3", "sample after clean period");
        check(d4_yel, 1'b0, "R4", "level after 1 period");
        send_period(0, 0, 0, 0);
        check(d4_yel, 1'b0, "R4", "level after 2 periods");
        send_period(0, 0, 0, 0);
        check(d4_yel, 1'b1, "R4", "level after 3 periods");
        send_period(4, 4, 4, 4);
        check(d4_yel48, 1'b1, "R2", "16 ones pass");
        send_period(5, 4, 4, 4);
        check(d4_yel48, 1'b0, "R2", "17 ones fail");
        check(d4_yel, 1'b1, "R5", "level after 1 fail");
        send_period(0, 0, 0, 0);
        send_period(24, 0, 0, 0);
        check(d4_yel, 1'b1, "R5", "fail run restarted by pass");
        send_period(24, 24, 0, 0);
        check(d4_yel, 1'b0, "R5", "level after 2 fails");
        check(d4_yel48, 1'b0, "R3", "sample held after fail");
    endtask

    task automatic t_d4_in_esf();
        do_reset(1'b1);
        send_period(0, 0, 0, 0); send_period(0, 0, 0, 0); send_period(0, 0, 0, 0);
        check(d4_yel48, 1'b0, "R10", "sample in ESF mode");
        check(d4_yel, 1'b0, "R10", "level in ESF mode");
    endtask

    task automatic t_sbit();
        do_reset(1'b0);
        drive(1'b1, 8'd0, 5'd11); idle();
        check(d4_yel_sec, 1'b0, "R6", "one S-bit");
        drive(1'b1, 8'd0, 5'd11); idle();
        check(d4_yel_sec, 1'b1, "R6", "two S-bits");
        drive(1'b0, 8'd0, 5'd11); idle();
        check(d4_yel_sec, 1'b0, "R6", "S-bit zero");
        drive(1'b1, 8'd0, 5'd11); drive(1'b0, 8'd0, 5'd5); idle();
        check(d4_yel_sec, 1'b0, "R6", "wrong frame ignored");
        drive(1'b1, 8'd0, 5'd11); idle();
        check(d4_yel_sec, 1'b1, "R6", "history kept over wrong frame");
    endtask

    task automatic send_cw(input logic [15:0] cw);
        for (int i = 15; i >= 0; i--) begin
            drive(cw[i], 8'd0, 5'((2 * dl_idx) % 24));
            dl_idx++;
        end
        idle();
    endtask

    task automatic t_esf();
        do_reset(1'b1);
        for (int k = 0; k < 6; k++) send_cw(16'h00FF);
        check(esf_yel, 1'b0, "R8", "6 of 10");
        send_cw(16'h00FF);
        check(esf_yel, 1'b1, "R8", "7 of 10");
        send_cw(16'h00FE);
        send_cw(16'hFF00);
        send_cw(16'h01FF);
        check(esf_yel, 1'b1, "R7", "7 of 10 after 3 near-miss words");
        send_cw(16'h00FF);
        check(esf_yel, 1'b1, "R8", "window slides");
        send_cw(16'h0000);
        check(esf_yel, 1'b0, "R8", "back to 6 of 10");
        do_reset(1'b0);
        for (int k = 0; k < 8; k++) send_cw(16'h00FF);
        check(esf_yel, 1'b0, "R10", "codewords in D4 mode");
    endtask

    task automatic send_win(input int zeros, input int nbits);
        for (int i = 0; i < nbits; i++) drive((i >= zeros), 8'd5, 5'd1);
        idle();
    endtask

    task automatic t_blue();
        do_reset(1'b0);
        send_win(5, WIN);
        check(blue, 1'b1, "R9", "5 zeros");
        send_win(6, WIN - 1);
        check(blue, 1'b1, "R9", "held mid-window");
        send_win(0, 1);
        check(blue, 1'b0, "R9", "6 zeros");
        send_win(0, WIN);
        check(blue, 1'b1, "R9", "no zeros");
        repeat (5) @(negedge clk);
        check(blue, 1'b1, "R11", "held without strobe");
    endtask

    initial begin
        t_reset();
        t_d4();
        t_d4_in_esf();
        t_sbit();
        t_esf();
        t_blue();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule